// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer for a small microcontroller. A slow clock enable (nominally 250 kHz, synchronous to the system clock) feeds a prescaler. The prescaler divides it by a power of two chosen by a 4-bit select field. An 8-bit counter then counts 256 prescaled ticks. When that counter wraps, the block sends the chip a one-cycle reset request and sets a sticky cause flag. Firmware keeps the chip alive by writing a fixed code to a kick register before the period runs out. A fuse input from nonvolatile configuration can hold the watchdog off whatever software does.

The block has three byte registers on a simple register bus: a key register, a control register and a kick register. The control register is read-only unless firmware first writes a three-value key sequence. That sequence grants exactly one control write. The reset request also stops the counting and returns the control fields to their defaults. The cause flag keeps its value so that firmware can see why the chip restarted.

Top module: `wdog_top`

## Requirements
- R1: After `rst`, the control register reads 0x04, the key, kick and unused addresses read 0x00, and `wd_reset_req` is low.
- R2: With enable set and the fuse low, `wd_reset_req` rises on the clock edge that takes tick number 256·2^sel since the last restart, and is high in the following cycle.
- R3: `wd_reset_req` is high for one cycle only. That pulse sets enable back to 0 and select back to 4 and clears both counters. It leaves the cause flag unchanged.
- R4: The cause flag (control bit 7) is set on overflow. A granted control write with bit 7 = 0 clears it, and a write with bit 7 = 1 does not change it. `rst` clears it. The overflow wins over a clearing write made in the same cycle.
- R5: A control write made without a grant has no effect on the control register.
- R6: Key writes (address 0) of 0x55, 0xAA and 0x5A, made as consecutive bus accesses, grant exactly one following control write (address 1). The lock then closes again.
- R7: Any other bus access between the key writes aborts the sequence: a read of any address, a write to another address, or a wrong key value. A key write of 0x55 always starts a new sequence. Cycles with no bus access do not affect the sequence.
- R8: Writing 0x55 to the kick register (address 2) clears the prescaler and the counter. Any other value has no effect. A kick in the cycle of the final tick prevents the timeout.
- R9: While the fuse input `cfg_dog_off` is high, or enable (control bit 5) is 0, the watchdog does not count and both counters are held at zero.
- R10: A granted write that changes select (control bits 3:0) restarts the period from zero. A granted write that keeps the same select and enable does not disturb the count.
- R11: The control register reads as {flag, 0, enable, 0, select[3:0]}. Address 3 and the write-only key and kick registers read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on / pin reset |
| tick_en | input | 1 | One-cycle enable from the slow watchdog clock source |
| cfg_dog_off | input | 1 | Fuse setting: 1 holds the watchdog off |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address: 0 key, 1 control, 2 kick |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| wd_reset_req | output | 1 | One-cycle chip reset request on timeout |

## Verification
The assertions assume that the bus makes at most one access per cycle and never raises read and write together. They also assume that `tick_en` and the fuse are synchronous levels sampled at the clock edge. The stimulus drives every input at the falling edge and issues one bus operation per task call. A random phase mixes key, control, kick and read accesses with the slow tick held low, so that unlock behaviour can be checked apart from timeouts. Directed phases then drive exact tick counts around each period boundary.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;
    localparam int SEL_W  = 4;
    localparam int PRE_W  = (1 << SEL_W) - 1;

    localparam logic [ADDR_W-1:0] A_KEY  = 2'd0;
    localparam logic [ADDR_W-1:0] A_CTL  = 2'd1;
    localparam logic [ADDR_W-1:0] A_KICK = 2'd2;

    localparam logic [DATA_W-1:0] KEY_FIRST  = 8'h55;
    localparam logic [DATA_W-1:0] KEY_SECOND = 8'hAA;
    localparam logic [DATA_W-1:0] KEY_THIRD  = 8'h5A;
    localparam logic [DATA_W-1:0] KICK_CODE  = 8'h55;

    localparam int FLAG_BIT = 7;
    localparam int EN_BIT   = 5;
    localparam logic [SEL_W-1:0] SEL_RESET = 4'd4;

    typedef enum logic [1:0] {LK_IDLE, LK_ONE, LK_TWO, LK_OPEN} lock_e;

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
    } cfg_t;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_t;

    localparam cfg_t CFG_RESET = '{en: 1'b0, sel: SEL_RESET};

    function automatic cfg_t cfg_from(logic [DATA_W-1:0] d);
        cfg_t c;
        c.en  = d[EN_BIT];
        c.sel = d[SEL_W-1:0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctl(logic flag, cfg_t c);
        logic [DATA_W-1:0] r;
        r = '0;
        r[FLAG_BIT]  = flag;
        r[EN_BIT]    = c.en;
        r[SEL_W-1:0] = c.sel;
        return r;
    endfunction

    // low 'sel' bits set: terminal value of the prescaler
    function automatic logic [PRE_W-1:0] div_mask(logic [SEL_W-1:0] sel);
        logic [PRE_W-1:0] m;
        for (int i = 0; i < PRE_W; i++) m[i] = (i < int'(sel));
        return m;
    endfunction
endpackage

// File: rtl/wdog_unlock.sv
module wdog_unlock
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  bus_t bus,
    output logic grant
);
    lock_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (bus.wr || bus.rd) begin
            st_d = LK_IDLE;
            if (bus.wr && bus.addr == A_KEY) begin
                if (bus.data == KEY_FIRST)                          st_d = LK_ONE;
                else if (st_q == LK_ONE && bus.data == KEY_SECOND)  st_d = LK_TWO;
                else if (st_q == LK_TWO && bus.data == KEY_THIRD)   st_d = LK_OPEN;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) st_q <= LK_IDLE;
        else            st_q <= st_d;
    end

    assign grant = (st_q == LK_OPEN) && bus.wr && (bus.addr == A_CTL);

    // R6: one write per unlock
    assert_relock_R6: assert property (@(posedge clk) disable iff (rst)
        grant |=> (st_q != LK_OPEN));
    // R7: a read mid-sequence aborts it
    assert_read_abort_R7: assert property (@(posedge clk) disable iff (rst)
        (bus.rd && !bus.wr && st_q != LK_IDLE) |=> (st_q == LK_IDLE));
    // R7: idle bus cycles keep the sequence
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!bus.rd && !bus.wr && !clr) |=> $stable(st_q));
endmodule

// File: rtl/wdog_ctl.sv
module wdog_ctl
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              grant,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ovf,
    output cfg_t              cfg_q,
    output logic              flag_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            cfg_q  <= CFG_RESET;
        end else begin
            if (ovf)                           flag_q <= 1'b1;
            else if (grant && !wdata[FLAG_BIT]) flag_q <= 1'b0;
            if (clr)        cfg_q <= CFG_RESET;
            else if (grant) cfg_q <= cfg_from(wdata);
        end
    end

    // R4: overflow always sets the flag
    assert_flag_set_R4: assert property (@(posedge clk) disable iff (rst)
        ovf |=> flag_q);
    // R3: the reset pulse leaves the flag in place
    assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !grant) |=> flag_q);
    // R5: fields move only on a grant or the reset pulse
    assert_cfg_locked_R5: assert property (@(posedge clk) disable iff (rst)
        (!grant && !clr) |=> $stable(cfg_q));
endmodule

// File: rtl/wdog_count.sv
module wdog_count
    import wdog_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    input  logic             kick,
    input  logic             restart,
    output logic             ovf,
    output logic             req_q
);
    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pre_done;
    logic             clear;

    assign pre_done = (pre_q == div_mask(sel));
    assign clear    = restart || kick || !run;
    assign ovf      = run && tick && pre_done && (&cnt_q) && !clear;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (tick) begin
            if (pre_done) begin
                pre_q <= '0;
                cnt_q <= cnt_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) req_q <= 1'b0;
        else     req_q <= ovf;
    end

    // R3: single-cycle request
    assert_req_single_R3: assert property (@(posedge clk) disable iff (rst)
        req_q |=> !req_q);
    // R2: request only after the counter sat at its top value
    assert_req_from_top_R2: assert property (@(posedge clk) disable iff (rst)
        req_q |-> (&$past(cnt_q)));
    // R9: stopped watchdog holds zero
    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !run |=> (pre_q == '0 && cnt_q == '0));
    // R8: a kick clears and blocks the request
    assert_kick_clear_R8: assert property (@(posedge clk) disable iff (rst)
        kick |=> (cnt_q == '0 && !req_q));
endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              cfg_dog_off,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wd_reset_req
);
    bus_t bus;
    cfg_t cfg;
    logic flag, grant, ovf, kick, run, sel_restart;

    assign bus         = '{wr: bus_wr, rd: bus_rd, addr: bus_addr, data: bus_wdata};
    assign kick        = bus_wr && (bus_addr == A_KICK) && (bus_wdata == KICK_CODE);
    assign run         = cfg.en && !cfg_dog_off;
    assign sel_restart = wd_reset_req || (grant && (cfg_from(bus_wdata).sel != cfg.sel));

    wdog_unlock u_unlock (
        .clk(clk), .rst(rst), .clr(wd_reset_req), .bus(bus), .grant(grant)
    );

    wdog_ctl u_ctl (
        .clk(clk), .rst(rst), .clr(wd_reset_req), .grant(grant),
        .wdata(bus_wdata), .ovf(ovf), .cfg_q(cfg), .flag_q(flag)
    );

    wdog_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst(rst), .tick(tick_en), .run(run), .sel(cfg.sel),
        .kick(kick), .restart(sel_restart), .ovf(ovf), .req_q(wd_reset_req)
    );

    always_comb begin
        case (bus_addr)
            A_CTL:   bus_rdata = pack_ctl(flag, cfg);
            default: bus_rdata = '0;
        endcase
    end

    // R9: fuse blocks any request
    assert_fuse_block_R9: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_dog_off) |-> !wd_reset_req);
    // R3: request returns the fields to default
    assert_req_defaults_R3: assert property (@(posedge clk) disable iff (rst)
        wd_reset_req |=> (cfg == CFG_RESET && flag));
endmodule

// File: tb/test_wdog_top.sv
module test_wdog_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       cfg_dog_off = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       wd_reset_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wdog_top i_wdog_top (
        .clk(clk), .rst(rst), .tick_en(tick_en), .cfg_dog_off(cfg_dog_off),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wd_reset_req(wd_reset_req)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int period(int sel);
        return 256 << sel;
    endfunction

    task automatic wr(logic [1:0] a, logic [7:0] d, bit with_tick = 1'b0);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick_en = with_tick;
        @(negedge clk);
        bus_wr = 1'b0; tick_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic unlock_write(logic [7:0] d);
        wr(2'd0, 8'h55); wr(2'd0, 8'hAA); wr(2'd0, 8'h5A); wr(2'd1, d);
    endtask

    // n tick pulses; records how many request cycles and the tick count at the last one
    task automatic ticks(int n, output int hits, output int last);
        hits = 0; last = -1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (wd_reset_req) begin hits++; last = i; end
            tick_en = 1'b1;
        end
        @(negedge clk);
        tick_en = 1'b0;
        if (wd_reset_req) begin hits++; last = n; end
    endtask

    task automatic expect_ctl(logic [7:0] exp, string req);
        logic [7:0] v;
        rd(2'd1, v);
        chk(v == exp, req, v, exp);
    endtask

    // bench-side unlock model from R6/R7
    function automatic int lock_next(int st, bit w, bit r, logic [1:0] a, logic [7:0] d);
        if (!w && !r) return st;
        if (w && a == 2'd0 && d == 8'h55) return 1;
        if (st == 1 && w && a == 2'd0 && d == 8'hAA) return 2;
        if (st == 2 && w && a == 2'd0 && d == 8'h5A) return 3;
        return 0;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL run hung: actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        int h, l;
        int m_st;
        bit m_flag, m_en;
        logic [3:0] m_sel;
        void'($urandom(32'd4242));

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 / R11 reset values
        chk(wd_reset_req == 1'b0, "R1 req idle", wd_reset_req, 0);
        expect_ctl(8'h04, "R1 ctl reset");
        rd(2'd0, v); chk(v == 8'h00, "R11 key reads 0", v, 0);
        rd(2'd2, v); chk(v == 8'h00, "R11 kick reads 0", v, 0);
        rd(2'd3, v); chk(v == 8'h00, "R11 unused reads 0", v, 0);

        // R5 locked write ignored
        wr(2'd1, 8'h2F);
        expect_ctl(8'h04, "R5 locked write");

        // R6 grant then relock
        unlock_write(8'h20);
        expect_ctl(8'h20, "R6 granted write");
        wr(2'd1, 8'h2F);
        expect_ctl(8'h20, "R6 relock after one write");

        // R2 / R3 timeout at sel 0
        ticks(period(0) + 3, h, l);
        chk(h == 1, "R3 one request cycle", h, 1);
        chk(l == period(0), "R2 timeout sel0", l, period(0));
        expect_ctl(8'h84, "R3 fields default, flag kept R4");

        // R4 write 1 keeps flag, sel 1 timeout
        unlock_write(8'hA1);
        expect_ctl(8'hA1, "R4 flag write 1 keeps");
        ticks(period(1) + 3, h, l);
        chk(h == 1 && l == period(1), "R2 timeout sel1", l, period(1));
        unlock_write(8'h22);
        expect_ctl(8'h22, "R4 flag cleared by write 0");

        // R7 aborted sequences
        wr(2'd0, 8'h55); rd(2'd1, v); wr(2'd0, 8'hAA); wr(2'd0, 8'h5A); wr(2'd1, 8'h00);
        expect_ctl(8'h22, "R7 read aborts");
        wr(2'd0, 8'h55); wr(2'd0, 8'hAA); wr(2'd0, 8'h12); wr(2'd0, 8'h5A); wr(2'd1, 8'h00);
        expect_ctl(8'h22, "R7 wrong key aborts");
        wr(2'd0, 8'h55); wr(2'd2, 8'h11); wr(2'd0, 8'hAA); wr(2'd0, 8'h5A); wr(2'd1, 8'h00);
        expect_ctl(8'h22, "R7 other address aborts");
        wr(2'd0, 8'h55); wr(2'd0, 8'h55); wr(2'd0, 8'hAA); wr(2'd0, 8'h5A); wr(2'd1, 8'h23);
        expect_ctl(8'h23, "R7 first key restarts");

        // R8 kick behaviour at sel 3
        ticks(1000, h, l);
        chk(h == 0, "R8 no early request", h, 0);
        wr(2'd2, 8'h55);
        ticks(period(3) + 3, h, l);
        chk(h == 1 && l == period(3), "R8 kick restarts period", l, period(3));
        unlock_write(8'h23);
        ticks(1000, h, l);
        wr(2'd2, 8'hAA);
        ticks(period(3) - 1000 + 3, h, l);
        chk(h == 1 && l == period(3) - 1000, "R8 wrong kick ignored", l, period(3) - 1000);
        unlock_write(8'h23);
        ticks(period(3) - 1, h, l);
        wr(2'd2, 8'h55, 1'b1);
        chk(wd_reset_req == 1'b0, "R8 kick beats final tick", wd_reset_req, 0);
        ticks(period(3) + 3, h, l);
        chk(h == 1 && l == period(3), "R8 period after final kick", l, period(3));

        // R9 fuse and enable hold counters at zero
        unlock_write(8'h20);
        ticks(100, h, l);
        cfg_dog_off = 1'b1;
        ticks(600, h, l);
        chk(h == 0, "R9 fuse blocks", h, 0);
        cfg_dog_off = 1'b0;
        ticks(period(0) + 3, h, l);
        chk(h == 1 && l == period(0), "R9 fuse cleared counters", l, period(0));
        unlock_write(8'h20);
        ticks(100, h, l);
        unlock_write(8'h00);
        ticks(600, h, l);
        chk(h == 0, "R9 enable 0 blocks", h, 0);
        unlock_write(8'h20);
        ticks(period(0) + 3, h, l);
        chk(h == 1 && l == period(0), "R9 disable cleared counters", l, period(0));

        // R10 select change restarts, same select does not
        unlock_write(8'h20);
        ticks(100, h, l);
        unlock_write(8'h21);
        ticks(period(1) + 3, h, l);
        chk(h == 1 && l == period(1), "R10 new sel restarts", l, period(1));
        unlock_write(8'h20);
        ticks(100, h, l);
        unlock_write(8'h20);
        ticks(period(0) - 100 + 3, h, l);
        chk(h == 1 && l == period(0) - 100, "R10 same sel keeps count", l, period(0) - 100);

        // R6 / R7 random accesses against the model, no ticks
        m_st = 0; m_flag = 1'b1; m_en = 1'b0; m_sel = 4'd4;
        for (int k = 0; k < 400; k++) begin
            int op;
            logic [1:0] a;
            logic [7:0] d;
            op = $urandom_range(0, 5);
            a = 2'($urandom_range(0, 3));
            case ($urandom_range(0, 4))
                0: d = 8'h55;
                1: d = 8'hAA;
                2: d = 8'h5A;
                default: d = 8'($urandom);
            endcase
            if (op == 0) begin
                rd(2'd1, v);
                chk(v == {m_flag, 1'b0, m_en, 1'b0, m_sel}, "R6 random ctl read",
                    v, {m_flag, 1'b0, m_en, 1'b0, m_sel});
                m_st = lock_next(m_st, 1'b0, 1'b1, 2'd1, 8'h00);
            end else if (op == 1) begin
                rd(a, v);
                m_st = lock_next(m_st, 1'b0, 1'b1, a, 8'h00);
            end else if (op == 2) begin
                @(negedge clk);
            end else begin
                if (op == 3) a = 2'd0;
                if (op == 4) a = 2'd1;
                wr(a, d);
                if (m_st == 3 && a == 2'd1) begin
                    if (!d[7]) m_flag = 1'b0;
                    m_en = d[5]; m_sel = d[3:0];
                end
                m_st = lock_next(m_st, 1'b1, 1'b0, a, d);
            end
        end
        expect_ctl({m_flag, 1'b0, m_en, 1'b0, m_sel}, "R7 random final state");
        chk(wd_reset_req == 1'b0, "R9 no request without ticks", wd_reset_req, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule